// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Collection

This block is the byte path that a SCSI host adapter uses for register-level transfers. It holds a small data buffer addressed by a read pointer and a write pointer, plus a signed counter of the bytes still to be moved. Host writes to the FIFO address land in that buffer. Host reads take bytes from it unless the bus is in the data-out phase. Whenever the buffer drains, both pointers return to zero.

While a command-collection flag is set, host writes are sent to a separate command buffer instead. When collection ends, the block raises a one-cycle ready pulse and the collected bytes can be read by index. The block can also preload a two-byte status response: the status byte, then zero. This load sets the fill level to two and raises an interrupt. Starting a selection or a new command empties the data buffer. A target-address field is decoded from the top three bits of the third buffered byte.

Top module: `pio_byte_path`

## Requirements
- R1: After reset, size_o is 0, flags_o is 0, irq_o is 0, cmd_mode_o is 0, cmd_len_o is 0, cmd_ready_o is 0, overrun_o is 0 and rd_data_o is 0.
- R2: A write (wr_i) outside command mode stores wdata_i. From the next cycle, size_o and flags_o are one higher.
- R3: After DEPTH-1 writes since the buffer was last empty, a further write is dropped. overrun_o is high for exactly the next cycle, and size_o is unchanged.
- R4: A read (rd_i) with phase_i not equal to 3'b000 and at least one unread byte places the oldest unread byte on rd_data_o from the next cycle. size_o is then one lower.
- R5: A read with phase_i equal to 3'b000 (data-out) puts 0 on rd_data_o and leaves size_o and flags_o unchanged.
- R6: A read with no unread byte puts 0 on rd_data_o and leaves size_o unchanged.
- R7: Reading the last unread byte returns both pointers to zero. A full DEPTH-1 writes are then accepted again with no overrun.
- R8: status_load_i stores status_i followed by 0x00, and makes size_o 2, flags_o 2 and irq_o 1 from the next cycle. irq_o stays high until irq_ack_i.
- R9: sel_start_i or cmd_begin_i clears size_o, flags_o and both pointers.
- R10: cmd_begin_i sets cmd_mode_o and zeroes cmd_len_o. Writes in command mode append to the command buffer, readable at cmd_idx_i on cmd_byte_o, and leave size_o unchanged.
- R11: In command mode, once CMD_DEPTH bytes are collected, a further write is dropped. overrun_o is high for the next cycle and cmd_len_o stays at CMD_DEPTH.
- R12: cmd_end_i in command mode clears cmd_mode_o and gives a one-cycle cmd_ready_o pulse on the next cycle, with cmd_len_o holding the byte count.
- R13: target_o equals bits 7:5 of the byte stored at buffer index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for the FIFO address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe for the FIFO address |
| phase_i | input | 3 | Bus phase bits; 3'b000 is data-out |
| rd_data_o | output | 8 | Registered read result |
| sel_start_i | input | 1 | Selection start; empties the data buffer |
| status_load_i | input | 1 | Preload the status response |
| status_i | input | 8 | Status byte for the response |
| irq_ack_i | input | 1 | Clears the interrupt |
| irq_o | output | 1 | Interrupt raised by a status load |
| cmd_begin_i | input | 1 | Enter command collection |
| cmd_end_i | input | 1 | Finish command collection |
| cmd_idx_i | input | 5 | Index into the command buffer |
| cmd_byte_o | output | 8 | Command byte at cmd_idx_i |
| cmd_len_o | output | 6 | Collected command byte count |
| cmd_mode_o | output | 1 | Command collection active |
| cmd_ready_o | output | 1 | One-cycle pulse when collection finishes |
| overrun_o | output | 1 | One-cycle pulse after a dropped write |
| size_o | output | 8 | Signed remaining-size counter |
| flags_o | output | 5 | Unread byte count, saturated |
| target_o | output | 3 | Target address decoded from buffer byte 2 |

## Verification
The hardest state to reach is a buffer whose write pointer sits at its limit. It only comes after DEPTH-1 writes with no intervening drain, and after the drain the write pointer must be shown back at zero. The stimulus fills the buffer to the limit and forces one dropped write. It then reads every byte back and fills the buffer again from empty, so that the pointer reset can only be seen as the absence of overrun. Command-buffer saturation is reached the same way, by collecting exactly CMD_DEPTH bytes and sending one more.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t STATUS_PAD = 8'h00;
endpackage

// File: rtl/pio_data_fifo.sv
module pio_data_fifo import pio_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     load_i,
  input  byte_t                    status_i,
  input  logic                     wr_i,
  input  byte_t                    wdata_i,
  input  logic                     rd_i,
  input  logic                     phase_ok_i,
  output byte_t                    rdata_o,
  output logic                     ovf_o,
  output logic signed [SIZE_W-1:0] size_o,
  output logic [PTR_W-1:0]         count_o,
  output logic [2:0]               target_o
);
  byte_t                    mem_q [DEPTH];
  logic [PTR_W-1:0]         wptr_q, rptr_q, wptr_n, rptr_n;
  logic signed [SIZE_W-1:0] size_q, size_n;
  byte_t                    rdata_q;
  logic                     ovf_q;
  logic                     rd_go, wr_go, wr_drop;

  always_comb begin
    rd_go   = rd_i && phase_ok_i && (rptr_q < wptr_q);
    wr_go   = wr_i && (wptr_q != PTR_W'(DEPTH-1));
    wr_drop = wr_i && !wr_go;
    wptr_n  = wptr_q + PTR_W'(wr_go);
    rptr_n  = rptr_q + PTR_W'(rd_go);
    if (wptr_n == rptr_n) begin
      wptr_n = '0;
      rptr_n = '0;
    end
    size_n = size_q;
    if (wr_go && !rd_go)      size_n = size_q + SIZE_W'(1);
    else if (rd_go && !wr_go) size_n = size_q - SIZE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      size_q  <= '0;
      rdata_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (clear_i) begin
        wptr_q <= '0;
        rptr_q <= '0;
        size_q <= '0;
      end else if (load_i) begin
        mem_q[0] <= status_i;
        mem_q[1] <= STATUS_PAD;
        rptr_q   <= '0;
        wptr_q   <= PTR_W'(2);
        size_q   <= SIZE_W'(2);
      end else begin
        if (wr_go) mem_q[wptr_q] <= wdata_i;
        if (rd_i)  rdata_q <= rd_go ? mem_q[rptr_q] : '0;
        ovf_q  <= wr_drop;
        wptr_q <= wptr_n;
        rptr_q <= rptr_n;
        size_q <= size_n;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign ovf_o    = ovf_q;
  assign size_o   = size_q;
  assign count_o  = wptr_q - rptr_q;
  assign target_o = mem_q[2][7:5];

  AST_PTR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_q <= wptr_q); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !clear_i && !load_i && wptr_q == PTR_W'(DEPTH-1))
    |=> (ovf_q && wptr_q == PTR_W'(DEPTH-1))); // R3
  AST_DRAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_ok_i && !wr_i && !clear_i && !load_i && rptr_q + PTR_W'(1) == wptr_q)
    |=> (wptr_q == '0 && rptr_q == '0)); // R7
  AST_DATAOUT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !phase_ok_i && !wr_i && !clear_i && !load_i)
    |=> (rdata_q == '0 && $stable(size_q))); // R5
endmodule

// File: rtl/pio_cmd_buf.sv
module pio_cmd_buf import pio_pkg::*; #(
  parameter int CMD_DEPTH = 32,
  localparam int CLEN_W = $clog2(CMD_DEPTH) + 1,
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              end_i,
  input  logic              wr_i,
  input  byte_t             wdata_i,
  input  logic [CIDX_W-1:0] idx_i,
  output logic              mode_o,
  output logic [CLEN_W-1:0] len_o,
  output logic              ready_o,
  output logic              ovf_o,
  output byte_t             byte_o
);
  byte_t             mem_q [CMD_DEPTH];
  logic [CLEN_W-1:0] len_q;
  logic              mode_q, ready_q, ovf_q;
  logic              room;

  assign room = len_q < CLEN_W'(CMD_DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CMD_DEPTH; i++) mem_q[i] <= '0;
      len_q   <= '0;
      mode_q  <= 1'b0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
      if (begin_i) begin
        mode_q <= 1'b1;
        len_q  <= '0;
      end else if (end_i) begin
        mode_q  <= 1'b0;
        ready_q <= mode_q;
      end else if (wr_i && mode_q) begin
        if (room) begin
          mem_q[len_q[CIDX_W-1:0]] <= wdata_i;
          len_q <= len_q + CLEN_W'(1);
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  assign mode_o  = mode_q;
  assign len_o   = len_q;
  assign ready_o = ready_q;
  assign ovf_o   = ovf_q;
  assign byte_o  = mem_q[idx_i];

  AST_CMD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_q && !begin_i && !end_i && len_q == CLEN_W'(CMD_DEPTH))
    |=> (ovf_q && $stable(len_q))); // R11
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q); // R12
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> !mode_q); // R12
endmodule

// File: rtl/pio_byte_path.sv
module pio_byte_path import pio_pkg::*; #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  parameter int SIZE_W    = 8,
  parameter int FLAG_W    = 5,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CLEN_W   = $clog2(CMD_DEPTH) + 1,
  localparam int CIDX_W   = $clog2(CMD_DEPTH),
  localparam int FLAG_MAX = 2**FLAG_W - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [7:0]               wdata_i,
  input  logic                     rd_i,
  input  logic [2:0]               phase_i,
  output logic [7:0]               rd_data_o,
  input  logic                     sel_start_i,
  input  logic                     status_load_i,
  input  logic [7:0]               status_i,
  input  logic                     irq_ack_i,
  output logic                     irq_o,
  input  logic                     cmd_begin_i,
  input  logic                     cmd_end_i,
  input  logic [CIDX_W-1:0]        cmd_idx_i,
  output logic [7:0]               cmd_byte_o,
  output logic [CLEN_W-1:0]        cmd_len_o,
  output logic                     cmd_mode_o,
  output logic                     cmd_ready_o,
  output logic                     overrun_o,
  output logic signed [SIZE_W-1:0] size_o,
  output logic [FLAG_W-1:0]        flags_o,
  output logic [2:0]               target_o
);
  logic             data_ovf, cmd_ovf, mode;
  logic [PTR_W-1:0] cnt;
  logic             irq_q;

  pio_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .begin_i (cmd_begin_i),
    .end_i   (cmd_end_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .idx_i   (cmd_idx_i),
    .mode_o  (mode),
    .len_o   (cmd_len_o),
    .ready_o (cmd_ready_o),
    .ovf_o   (cmd_ovf),
    .byte_o  (cmd_byte_o)
  );

  pio_data_fifo #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (sel_start_i | cmd_begin_i),
    .load_i     (status_load_i),
    .status_i   (status_i),
    .wr_i       (wr_i && !mode),
    .wdata_i    (wdata_i),
    .rd_i       (rd_i),
    .phase_ok_i (phase_i != 3'b000),
    .rdata_o    (rd_data_o),
    .ovf_o      (data_ovf),
    .size_o     (size_o),
    .count_o    (cnt),
    .target_o   (target_o)
  );

  generate
    if (PTR_W > FLAG_W) begin : g_cap
      assign flags_o = (cnt > PTR_W'(FLAG_MAX)) ? FLAG_W'(FLAG_MAX) : cnt[FLAG_W-1:0];
    end else begin : g_ext
      assign flags_o = FLAG_W'(cnt);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            irq_q <= 1'b0;
    else if (status_load_i) irq_q <= 1'b1;
    else if (irq_ack_i)     irq_q <= 1'b0;
  end

  assign irq_o      = irq_q;
  assign cmd_mode_o = mode;
  assign overrun_o  = data_ovf | cmd_ovf;

  AST_STATUS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_load_i && !sel_start_i && !cmd_begin_i)
    |=> (irq_o && flags_o == FLAG_W'(2) && size_o == SIZE_W'(2))); // R8
  AST_CMD_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode && wr_i && !rd_i && !sel_start_i && !cmd_begin_i && !status_load_i)
    |=> $stable(size_o)); // R10
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_start_i || cmd_begin_i) |=> (size_o == '0 && flags_o == '0)); // R9
endmodule

// File: tb/pio_byte_path_bench.sv
module pio_byte_path_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr = 0, rd = 0, sel = 0, sload = 0, ack = 0, cbeg = 0, cend = 0;
  logic [7:0] wdata = 0, status = 0;
  logic [2:0] phase = 0;
  logic [4:0] cidx = 0;
  logic [7:0] rd_data, cmd_byte;
  logic [5:0] cmd_len;
  logic       irq, cmd_mode, cmd_ready, overrun;
  logic signed [7:0] size;
  logic [4:0] flags;
  logic [2:0] target;

  pio_byte_path u_pio_byte_path (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .phase_i(phase), .rd_data_o(rd_data), .sel_start_i(sel),
    .status_load_i(sload), .status_i(status), .irq_ack_i(ack), .irq_o(irq),
    .cmd_begin_i(cbeg), .cmd_end_i(cend), .cmd_idx_i(cidx),
    .cmd_byte_o(cmd_byte), .cmd_len_o(cmd_len), .cmd_mode_o(cmd_mode),
    .cmd_ready_o(cmd_ready), .overrun_o(overrun), .size_o(size),
    .flags_o(flags), .target_o(target)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_byte(input logic [2:0] ph);
    @(negedge clk); rd = 1; phase = ph;
    @(negedge clk); rd = 0;
  endtask

  // op: 1 write, 2 read | data | phase | expected read | expected size
  localparam logic [28:0] TBL [0:9] = '{
    {2'd1, 8'hA5, 3'd0, 8'h00, 8'd1},
    {2'd1, 8'h3C, 3'd0, 8'h00, 8'd2},
    {2'd1, 8'hE1, 3'd0, 8'h00, 8'd3},
    {2'd2, 8'h00, 3'd1, 8'hA5, 8'd2},
    {2'd2, 8'h00, 3'd0, 8'h00, 8'd2},
    {2'd2, 8'h00, 3'd3, 8'h3C, 8'd1},
    {2'd1, 8'h77, 3'd0, 8'h00, 8'd2},
    {2'd2, 8'h00, 3'd1, 8'hE1, 8'd1},
    {2'd2, 8'h00, 3'd7, 8'h77, 8'd0},
    {2'd2, 8'h00, 3'd1, 8'h00, 8'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ovf_seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 size", int'(size), 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cmd_mode", cmd_mode, 0);
    chk("R1 cmd_len", cmd_len, 0);
    chk("R1 ready", cmd_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rd_data", rd_data, 0);

    for (int i = 0; i < 10; i++) begin
      logic [28:0] v;
      string tag;
      v = TBL[i];
      if (v[28:27] == 2'd1) begin
        wr_byte(v[26:19]);
        tag = "R2";
      end else begin
        rd_byte(v[18:16]);
        tag = (v[18:16] == 3'd0) ? "R5" : (i == 9) ? "R6" : "R4";
        chk({tag, " data"}, rd_data, int'(v[15:8]));
      end
      chk({tag, " size"}, int'(size), int'(v[7:0]));
      chk({tag, " flags"}, flags, int'(v[7:0]));
    end

    // fill to the limit from empty
    ovf_seen = 0;
    for (int i = 0; i < 15; i++) begin
      wr_byte(8'(i * 17));
      ovf_seen += overrun;
    end
    chk("R3 no early overrun", ovf_seen, 0);
    chk("R3 size full", int'(size), 15);
    chk("R13 target", target, 1);
    wr_byte(8'hFF);
    chk("R3 overrun pulse", overrun, 1);
    chk("R3 size kept", int'(size), 15);
    @(negedge clk);
    chk("R3 pulse ends", overrun, 0);
    for (int i = 0; i < 15; i++) begin
      rd_byte(3'd2);
      chk("R4 drain data", rd_data, (i * 17) & 255);
    end
    chk("R7 size empty", int'(size), 0);
    ovf_seen = 0;
    for (int i = 0; i < 15; i++) begin
      wr_byte(8'(8'hA0 + i));
      ovf_seen += overrun;
    end
    chk("R7 refill no overrun", ovf_seen, 0);
    chk("R7 refill size", int'(size), 15);
    chk("R13 target refill", target, 5);

    @(negedge clk); sel = 1; @(negedge clk); sel = 0;
    chk("R9 size cleared", int'(size), 0);
    chk("R9 flags cleared", flags, 0);

    @(negedge clk); sload = 1; status = 8'h8C; @(negedge clk); sload = 0;
    chk("R8 flags", flags, 2);
    chk("R8 size", int'(size), 2);
    chk("R8 irq", irq, 1);
    rd_byte(3'd3);
    chk("R8 status byte", rd_data, 8'h8C);
    rd_byte(3'd3);
    chk("R8 pad byte", rd_data, 0);
    chk("R8 drained", int'(size), 0);
    chk("R8 irq held", irq, 1);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    chk("R8 irq ack", irq, 0);

    // one byte in data buffer, then command mode must clear it
    wr_byte(8'h11);
    @(negedge clk); cbeg = 1; @(negedge clk); cbeg = 0;
    chk("R10 mode", cmd_mode, 1);
    chk("R10 len", cmd_len, 0);
    chk("R9 begin clears", int'(size), 0);
    wr_byte(8'hC1); wr_byte(8'hC2); wr_byte(8'hC3);
    chk("R10 len3", cmd_len, 3);
    chk("R10 data untouched", int'(size), 0);
    cidx = 5'd1; #1;
    chk("R10 cmd byte", cmd_byte, 8'hC2);
    ovf_seen = 0;
    for (int i = 3; i < 32; i++) begin
      wr_byte(8'(8'h40 + i));
      ovf_seen += overrun;
    end
    chk("R11 no early overrun", ovf_seen, 0);
    chk("R11 len full", cmd_len, 32);
    wr_byte(8'hEE);
    chk("R11 overrun", overrun, 1);
    chk("R11 len kept", cmd_len, 32);
    cidx = 5'd31; #1;
    chk("R11 last byte", cmd_byte, 8'h5F);
    @(negedge clk); cend = 1; @(negedge clk); cend = 0;
    chk("R12 mode off", cmd_mode, 0);
    chk("R12 ready", cmd_ready, 1);
    chk("R12 len", cmd_len, 32);
    @(negedge clk);
    chk("R12 ready pulse", cmd_ready, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule